// File: doc/BRIEF.md
# Converter bring-up and calibration sequencer

This controller sits beside a pipelined 14-bit analog-to-digital converter that can calibrate itself on command. It runs on the converter's sample clock. It drives four lines: the active-low power-down line, the reset line, the calibrate line and the active-low read-enable line. It also reads the active-low end-of-conversion flag and the 14-bit data bus. After power-up or after waking from sleep, it powers the converter and waits a fixed number of cycles for the references to settle. It then pulses reset, waits for the pipeline to drain, pulses calibrate and waits for the calibration to finish. After one more pipeline drain it enters its run state.

In the run state the controller enables the read path. On every clock where end-of-conversion is low, it captures the two's-complement word. The word is sign-extended to 16 bits and presented for one cycle with a valid strobe. There is no backpressure. Every word that the converter produces while reset or calibrate is high, or during the drain that follows either, is dropped.

A sleep request from any state sends the converter to power-down at once, and the whole sequence runs again on wake. A recalibration request in the run state restarts the sequence at the reset pulse. A ready flag is high only in the run state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_ni is low, adc_pd_no, adc_rst_o, adc_cal_o, ready_o and smp_valid_o are 0, adc_rd_no is 1 and smp_data_o is 0.
- R2: While sleep_req_i is high, adc_pd_no is 0. Once sleep_req_i is low, adc_pd_no goes to 1 and stays at 1 for SETTLE_CYC cycles before the reset pulse, with reset and calibrate both low.
- R3: adc_rst_o is high for exactly RST_CYC consecutive cycles (RST_CYC at least 2).
- R4: After adc_rst_o falls, adc_rst_o and adc_cal_o both stay low for exactly FLUSH_CYC cycles, then adc_cal_o rises.
- R5: adc_cal_o is high for exactly CAL_PULSE_CYC consecutive cycles (at least 2).
- R6: After adc_cal_o falls, the controller waits CAL_CYC cycles and then FLUSH_CYC cycles before ready_o goes high. ready_o is high only in the run state.
- R7: adc_rd_no is 0 exactly when ready_o is 1.
- R8: If the controller is in the run state and eoc_ni is low at a clock edge, then after that edge smp_valid_o is 1 for one cycle and smp_data_o holds adc_data_i sign-extended from bit 13. For example, 0x2000 becomes 0xE000 and 0x1FFF stays 0x1FFF.
- R9: smp_valid_o is 0 after any edge at which the controller was not in the run state or eoc_ni was high. These are the dropped words.
- R10: A sleep request in any state makes adc_pd_no 0 one cycle later and forces the other command lines inactive. On wake, the full settle, reset and calibrate sequence runs again.
- R11: A recalibration request in the run state, with no sleep request, raises adc_rst_o one cycle later and then repeats the reset, calibrate and drain steps.
- R12: adc_rst_o and adc_cal_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Host request to power the converter down |
| recal_req_i | input | 1 | Host request to recalibrate (acted on in run state) |
| eoc_ni | input | 1 | Converter end-of-conversion flag, low when a word is valid |
| adc_data_i | input | DW | Converter data bus, two's complement |
| adc_pd_no | output | 1 | Converter power-down, active low |
| adc_rst_o | output | 1 | Converter reset, active high level |
| adc_cal_o | output | 1 | Converter calibrate, active high level |
| adc_rd_no | output | 1 | Converter read enable, active low |
| ready_o | output | 1 | High while samples are being captured |
| smp_valid_o | output | 1 | One-cycle strobe for a captured sample |
| smp_data_o | output | OW | Captured sample, sign-extended |

## Verification
A wrong sequencer state shows at the ports within one cycle. The four command lines and ready_o are decoded directly from the state, so a stray transition shifts a pulse edge or shortens a pulse. A timer that is off by one moves an edge of the settle, pulse, calibration or drain window by one cycle. The bench compares every line on every cycle against its own timeline, so such an error is flagged on the cycle where the edge should have moved. A capture gate that is wrong shows on the next cycle as a strobe that appears during a drain window, or as a missing strobe in the run state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_RST,
    ST_RST_FLUSH,
    ST_CAL,
    ST_CAL_WAIT,
    ST_FLUSH,
    ST_RUN
  } seq_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC    = 250000,
  parameter int RST_CYC       = 2,
  parameter int CAL_PULSE_CYC = 2,
  parameter int CAL_CYC       = 272800,
  parameter int FLUSH_CYC     = 13,
  parameter int CW            = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_req_i,
  input  logic          recal_req_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output seq_st_e       state_o
);

  localparam logic [CW-1:0] SettleVal = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RstVal    = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] CalPVal   = CW'(CAL_PULSE_CYC - 1);
  localparam logic [CW-1:0] CalVal    = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] FlushVal  = CW'(FLUSH_CYC - 1);

  seq_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (sleep_req_i) begin
      st_d       = ST_OFF;
      tmr_load_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d = ST_SETTLE; tmr_load_o = 1'b1; tmr_val_o = SettleVal;
        end
        ST_SETTLE: if (tmr_zero_i) begin
          st_d = ST_RST; tmr_load_o = 1'b1; tmr_val_o = RstVal;
        end
        ST_RST: if (tmr_zero_i) begin
          st_d = ST_RST_FLUSH; tmr_load_o = 1'b1; tmr_val_o = FlushVal;
        end
        ST_RST_FLUSH: if (tmr_zero_i) begin
          st_d = ST_CAL; tmr_load_o = 1'b1; tmr_val_o = CalPVal;
        end
        ST_CAL: if (tmr_zero_i) begin
          st_d = ST_CAL_WAIT; tmr_load_o = 1'b1; tmr_val_o = CalVal;
        end
        ST_CAL_WAIT: if (tmr_zero_i) begin
          st_d = ST_FLUSH; tmr_load_o = 1'b1; tmr_val_o = FlushVal;
        end
        ST_FLUSH: if (tmr_zero_i) begin
          st_d = ST_RUN;
        end
        ST_RUN: if (recal_req_i) begin
          st_d = ST_RST; tmr_load_o = 1'b1; tmr_val_o = RstVal;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int DW = 14,
  parameter int OW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [OW-1:0] data_o
);

  logic [OW-1:0] ext;

  generate
    if (OW > DW) begin : g_sext
      assign ext = {{(OW-DW){data_i[DW-1]}}, data_i};
    end else begin : g_trunc
      assign ext = data_i[DW-1 -: OW];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_en_i;
      if (cap_en_i) data_o <= ext;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC    = 250000,
  parameter int RST_CYC       = 2,
  parameter int CAL_PULSE_CYC = 2,
  parameter int CAL_CYC       = 272800,
  parameter int FLUSH_CYC     = 13,
  parameter int DW            = 14,
  parameter int OW            = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_req_i,
  input  logic          recal_req_i,
  input  logic          eoc_ni,
  input  logic [DW-1:0] adc_data_i,
  output logic          adc_pd_no,
  output logic          adc_rst_o,
  output logic          adc_cal_o,
  output logic          adc_rd_no,
  output logic          ready_o,
  output logic          smp_valid_o,
  output logic [OW-1:0] smp_data_o
);

  localparam int MaxDur = max_of(max_of(max_of(SETTLE_CYC, CAL_CYC),
                                        max_of(RST_CYC, CAL_PULSE_CYC)), FLUSH_CYC);
  localparam int CW     = $clog2(MaxDur + 1);

  seq_st_e       state;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  adc_seq_fsm #(
    .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC), .CAL_PULSE_CYC(CAL_PULSE_CYC),
    .CAL_CYC(CAL_CYC), .FLUSH_CYC(FLUSH_CYC), .CW(CW)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i),
    .recal_req_i(recal_req_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .state_o(state)
  );

  adc_seq_timer #(.CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign adc_pd_no = (state != ST_OFF);
  assign adc_rst_o = (state == ST_RST);
  assign adc_cal_o = (state == ST_CAL);
  assign ready_o   = (state == ST_RUN);
  assign adc_rd_no = !ready_o;

  adc_seq_capture #(.DW(DW), .OW(OW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_en_i(ready_o && !eoc_ni),
    .data_i(adc_data_i), .valid_o(smp_valid_o), .data_o(smp_data_o)
  );

  // R3
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_rst_o) && adc_pd_no) |-> $past(adc_rst_o, 2));

  // R5
  cal_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_cal_o) && adc_pd_no) |-> $past(adc_cal_o, 2));

  // R12
  rst_cal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adc_rst_o && adc_cal_o));

  // R6
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (adc_pd_no && !adc_rst_o && !adc_cal_o));

  // R9
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(!eoc_ni && !adc_rd_no));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

  localparam int SETTLE = 20;
  localparam int RSTC   = 2;
  localparam int CALP   = 3;
  localparam int CALC   = 60;
  localparam int FLUSH  = 13;
  localparam int NCYC   = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, recal_req = 1'b0, eoc_n = 1'b1;
  logic [13:0] adc_data = '0;
  logic pd_n, rst_o, cal_o, rd_n, ready, vld;
  logic [15:0] dat;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(
    .SETTLE_CYC(SETTLE), .RST_CYC(RSTC), .CAL_PULSE_CYC(CALP),
    .CAL_CYC(CALC), .FLUSH_CYC(FLUSH), .DW(14), .OW(16)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .recal_req_i(recal_req),
    .eoc_ni(eoc_n), .adc_data_i(adc_data), .adc_pd_no(pd_n), .adc_rst_o(rst_o),
    .adc_cal_o(cal_o), .adc_rd_no(rd_n), .ready_o(ready),
    .smp_valid_o(vld), .smp_data_o(dat)
  );

  // reference timeline: 0 off,1 settle,2 rst,3 rst drain,4 cal,5 cal wait,6 drain,7 run
  int m_st = 0, m_cnt = 0;
  logic e_vld = 0;
  logic [15:0] e_dat = '0;

  function automatic logic [15:0] sext(input logic [13:0] d);
    return {{2{d[13]}}, d};
  endfunction

  function automatic int dur(input int s);
    case (s)
      1: return SETTLE; 2: return RSTC; 3: return FLUSH;
      4: return CALP;   5: return CALC; 6: return FLUSH;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; e_vld = 0; e_dat = '0;
    end else begin
      e_vld = (m_st == 7) && !eoc_n;
      if (e_vld) e_dat = sext(adc_data);
      if (sleep_req) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        m_st = 1; m_cnt = dur(1) - 1;
      end else if (m_st == 7) begin
        if (recal_req) begin m_st = 2; m_cnt = dur(2) - 1; end
      end else if (m_cnt == 0) begin
        m_st = m_st + 1; m_cnt = dur(m_st) - 1;
      end else m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done && cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog cyc=%0d act=1 exp=0", cyc);
      summary();
    end
  end

  int fall_cyc = -1000;
  bit prev_rst = 0, prev_cal = 0, recal_pending = 0, cw_sleep_done = 0;
  int force_sleep = 0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 pd", 16'(pd_n), 16'd0);
    chk("R1 rst", 16'(rst_o), 16'd0);
    chk("R1 cal", 16'(cal_o), 16'd0);
    chk("R1 rd", 16'(rd_n), 16'd1);
    chk("R1 ready", 16'(ready), 16'd0);
    chk("R1 valid", 16'(vld), 16'd0);
    chk("R1 data", dat, 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      chk("R10 pd", 16'(pd_n), 16'(m_st != 0));
      chk("R3 rst", 16'(rst_o), 16'(m_st == 2));
      chk("R5 cal", 16'(cal_o), 16'(m_st == 4));
      chk("R6 ready", 16'(ready), 16'(m_st == 7));
      chk("R7 rd", 16'(rd_n), 16'(m_st != 7));
      chk("R9 valid", 16'(vld), 16'(e_vld));
      if (e_vld) chk("R8 data", dat, e_dat);
      chk("R12 excl", 16'(rst_o && cal_o), 16'd0);
      if (recal_pending) chk("R11 rst", 16'(rst_o), 16'd1);
      if (prev_rst && !rst_o) fall_cyc = cyc;
      if (!prev_cal && cal_o) chk("R4 gap", 16'(cyc - fall_cyc), 16'(FLUSH));
      if (m_st == 1 && m_cnt == SETTLE - 1) chk("R2 settle", 16'(pd_n && !rst_o), 16'd1);
      prev_rst = rst_o; prev_cal = cal_o;

      // stimulus
      eoc_n = ($urandom_range(3) == 0);
      case ($urandom_range(7))
        0: adc_data = 14'h2000;
        1: adc_data = 14'h1FFF;
        default: adc_data = 14'($urandom);
      endcase
      if (!cw_sleep_done && m_st == 5 && m_cnt == 10) begin
        force_sleep = 3; cw_sleep_done = 1;
      end
      if (force_sleep > 0) begin
        sleep_req = 1'b1; force_sleep--;
      end else if (i < 300) sleep_req = 1'b0;
      else if (sleep_req) sleep_req = ($urandom_range(19) != 0);
      else sleep_req = ($urandom_range(599) == 0);
      recal_req = (ready && $urandom_range(149) == 0);
      recal_pending = recal_req && ready && !sleep_req;
    end
    done = 1;
    summary();
  end

endmodule